// File: doc/BRIEF.md
# Extended capability chain walker

This block walks a linked list of 32-bit capability headers held in a configuration space memory. The list always starts at byte offset 0x100. Each header carries a capability ID, a version and the byte offset of the next header. A search request returns whether the ID was found, the offset of the matching header, and the offset of the header visited just before it. The block reaches the memory through a single-port read/write interface whose read data comes back one cycle after the request.

The block also appends a capability. The caller gives an ID, a version and an offset. When the offset is 0x100, the header at that location is rewritten and keeps the link it already had. For any other offset, the walker first finds the tail of the list. It then rewrites only the tail's link field so that it points at the new offset, and writes the new header with an empty link.

The walk checks every link before it follows it. A link that falls outside the legal window or is not word aligned ends the operation with an error code. A step counter ends the operation when the list appears to loop.

Top module: `ecap_chain_walker`

## Requirements
- R1: A header word holds the ID in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. The memory word address is the byte offset divided by 4. Read data is valid in the cycle after a request with `mem_we` low.
- R2: A search starts at offset 0x100 and follows the links. On a matching nonzero ID it ends with `found`=1, `err_code`=0, `cap_ofs` set to the offset of the match, and `prev_ofs` set to the offset of the header visited before the match. `prev_ofs` is 0 when the match is at 0x100.
- R3: If the header at 0x100 is all zero, a search ends with `found`=0, `err_code`=0 and `prev_ofs`=0. An append to any offset other than 0x100 ends with `err_code`=4 and makes no write.
- R4: A search for ID 0 never matches. A search that reaches a header whose next field is 0 ends with `found`=0, `err_code`=0 and `prev_ofs` equal to the offset of that last header.
- R5: A next offset below 0x100 or above 0xFF8 ends the operation with `err_code`=1. This range error takes priority over the alignment error. An offset of exactly 0xFF8 is legal.
- R6: A next offset that lies inside the window but has either of its two low bits set ends the operation with `err_code`=2.
- R7: When the walk must follow a link after it has already read `STEP_LIMIT` headers, it ends with `err_code`=3. A list of exactly `STEP_LIMIT` headers completes normally.
- R8: An append at 0x100 writes exactly one word there: the new ID and version, together with the next field that was already stored at 0x100.
- R9: An append at any other offset makes exactly two writes. First it rewrites the tail header with its next field set to the new offset, keeping bits 19:0 unchanged. Then it writes the new header with next field 0. The operation reports `prev_ofs` equal to the tail offset and `cap_ofs` equal to the new offset.
- R10: An append offset outside 0x100 to 0xFF8 ends with `err_code`=1, and a misaligned one ends with `err_code`=2. In both cases the block makes no memory access.
- R11: `done` is a one-cycle pulse that ends every accepted operation. `op_valid` is ignored while `busy` is high. The result outputs hold their values until the next operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Start an operation (taken only while idle) |
| op_append | input | 1 | 1 = append, 0 = search |
| op_id | input | 16 | Capability ID to find or to append |
| op_ver | input | 4 | Version of the appended header |
| op_ofs | input | 12 | Byte offset of the appended header |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Search matched |
| err_code | output | 3 | 0 none, 1 range, 2 alignment, 3 step limit, 4 empty list |
| cap_ofs | output | 12 | Offset of the match, or of the appended header |
| prev_ofs | output | 12 | Offset of the preceding header (or the tail) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |

## Verification
The assertions rely on the memory returning, in the next cycle, the word at the address requested. They also rely on no other agent writing the memory while an operation is running, so that a header read during the walk is the one that gets patched. The bench models the memory with exactly that one-cycle latency. It rewrites the memory contents only between operations, when `busy` is low. The one exception is the test that presents new requests while the walker is busy, and that test touches only `op_*` pins.

// File: rtl/ecw_pkg.sv
package ecw_pkg;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_RANGE = 3'd1,
      ERR_ALIGN = 3'd2,
      ERR_LOOP  = 3'd3,
      ERR_EMPTY = 3'd4
   } ecw_err_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_READ,
      S_EVAL,
      S_WR_TAIL,
      S_WR_NEW,
      S_FIN
   } ecw_state_e;

endpackage

// File: rtl/ecw_ptr_check.sv
// Classifies a byte offset against the legal header window and alignment.
module ecw_ptr_check #(
   parameter int OFS_W       = 12,
   parameter int BASE_OFS    = 256,
   parameter int SPACE_BYTES = 4096,
   parameter int ALIGN_BYTES = 4
) (
   input  logic [OFS_W-1:0] ptr,
   output logic             bad_range,
   output logic             bad_align
);
   localparam int AL_B = $clog2(ALIGN_BYTES);
   localparam logic [OFS_W-1:0] LO_P = OFS_W'(BASE_OFS);
   localparam logic [OFS_W-1:0] HI_P = OFS_W'(SPACE_BYTES - 8);

   if (SPACE_BYTES > (1 << OFS_W)) begin : g_bad_space
      $error("ecw_ptr_check: SPACE_BYTES does not fit in OFS_W");
   end
   if (BASE_OFS >= SPACE_BYTES - 8) begin : g_bad_base
      $error("ecw_ptr_check: BASE_OFS leaves no room for headers");
   end
   if ((1 << AL_B) != ALIGN_BYTES) begin : g_bad_align
      $error("ecw_ptr_check: ALIGN_BYTES must be a power of two");
   end

   assign bad_range = (ptr < LO_P) || (ptr > HI_P);

   if (AL_B == 0) begin : g_no_align
      assign bad_align = 1'b0;
   end else begin : g_align
      assign bad_align = |ptr[AL_B-1:0];
   end

endmodule

// File: rtl/ecw_step_guard.sv
// Counts header reads during one walk and flags when the limit is reached.
module ecw_step_guard #(
   parameter int LIMIT = 1024,
   parameter bit EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic at_limit
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("ecw_step_guard: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (bump && (cnt != LIM_C)) begin
         cnt <= cnt + 1'b1;
      end
   end

   if (EN) begin : g_guard
      assign at_limit = (cnt >= LIM_C);
   end else begin : g_noguard
      assign at_limit = 1'b0;
   end

endmodule

// File: rtl/ecw_hdr_pack.sv
// Builds the two header words an append writes.
module ecw_hdr_pack #(
   parameter int ID_W  = 16,
   parameter int VER_W = 4,
   parameter int OFS_W = 12
) (
   input  logic [ID_W+VER_W+OFS_W-1:0] old_hdr,
   input  logic [OFS_W-1:0]            link_ofs,
   input  logic [ID_W-1:0]             id,
   input  logic [VER_W-1:0]            ver,
   input  logic [OFS_W-1:0]            tail_next,
   output logic [ID_W+VER_W+OFS_W-1:0] patched_hdr,
   output logic [ID_W+VER_W+OFS_W-1:0] new_hdr
);
   localparam int KEEP_W = ID_W + VER_W;
   localparam int HDR_W  = KEEP_W + OFS_W;

   logic [OFS_W-1:0] unused_old_link;
   assign unused_old_link = old_hdr[HDR_W-1 -: OFS_W];

   assign patched_hdr = {link_ofs, old_hdr[KEEP_W-1:0]};
   assign new_hdr     = {tail_next, ver, id};

endmodule

// File: rtl/ecap_chain_walker.sv
module ecap_chain_walker
   import ecw_pkg::*;
#(
   parameter int OFS_W       = 12,
   parameter int ID_W        = 16,
   parameter int VER_W       = 4,
   parameter int DATA_W      = 32,
   parameter int BASE_OFS    = 256,
   parameter int SPACE_BYTES = 4096,
   parameter int ALIGN_BYTES = 4,
   parameter int STEP_LIMIT  = 1024,
   parameter bit GUARD_EN    = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    op_valid,
   input  logic                                    op_append,
   input  logic [ID_W-1:0]                         op_id,
   input  logic [VER_W-1:0]                        op_ver,
   input  logic [OFS_W-1:0]                        op_ofs,
   output logic                                    busy,
   output logic                                    done,
   output logic                                    found,
   output logic [2:0]                              err_code,
   output logic [OFS_W-1:0]                        cap_ofs,
   output logic [OFS_W-1:0]                        prev_ofs,
   output logic                                    mem_req,
   output logic                                    mem_we,
   output logic [OFS_W-$clog2(ALIGN_BYTES)-1:0]    mem_addr,
   output logic [DATA_W-1:0]                       mem_wdata,
   input  logic [DATA_W-1:0]                       mem_rdata
);
   localparam int AL_B  = $clog2(ALIGN_BYTES);
   localparam int HDR_W = ID_W + VER_W + OFS_W;
   localparam logic [OFS_W-1:0] BASE_P = OFS_W'(BASE_OFS);

   if (DATA_W != HDR_W) begin : g_bad_width
      $error("ecap_chain_walker: header fields must fill DATA_W exactly");
   end

   ecw_state_e       st;
   logic             app_q, first_q;
   logic [ID_W-1:0]  tgt_q;
   logic [VER_W-1:0] ver_q;
   logic [OFS_W-1:0] nofs_q, cur_q, prv_q, nnext_q;
   logic [HDR_W-1:0] tail_q;
   logic             found_q;
   ecw_err_e         err_q;
   logic [OFS_W-1:0] cap_q, prev_q;

   logic [ID_W-1:0]  rd_id;
   logic [OFS_W-1:0] rd_next;
   logic             nxt_bad_range, nxt_bad_align;
   logic             new_bad_range, new_bad_align;
   logic             at_limit, accept;
   logic [HDR_W-1:0] patched_hdr, new_hdr;

   assign rd_id   = mem_rdata[ID_W-1:0];
   assign rd_next = mem_rdata[HDR_W-1 -: OFS_W];
   assign accept  = (st == S_IDLE) && op_valid;

   ecw_ptr_check #(
      .OFS_W(OFS_W), .BASE_OFS(BASE_OFS),
      .SPACE_BYTES(SPACE_BYTES), .ALIGN_BYTES(ALIGN_BYTES)
   ) u_next_chk (
      .ptr(rd_next), .bad_range(nxt_bad_range), .bad_align(nxt_bad_align)
   );

   ecw_ptr_check #(
      .OFS_W(OFS_W), .BASE_OFS(BASE_OFS),
      .SPACE_BYTES(SPACE_BYTES), .ALIGN_BYTES(ALIGN_BYTES)
   ) u_new_chk (
      .ptr(op_ofs), .bad_range(new_bad_range), .bad_align(new_bad_align)
   );

   ecw_step_guard #(
      .LIMIT(STEP_LIMIT), .EN(GUARD_EN)
   ) u_guard (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .bump(st == S_READ), .at_limit(at_limit)
   );

   ecw_hdr_pack #(
      .ID_W(ID_W), .VER_W(VER_W), .OFS_W(OFS_W)
   ) u_pack (
      .old_hdr(tail_q), .link_ofs(nofs_q), .id(tgt_q), .ver(ver_q),
      .tail_next(nnext_q), .patched_hdr(patched_hdr), .new_hdr(new_hdr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         app_q   <= 1'b0;
         first_q <= 1'b0;
         tgt_q   <= '0;
         ver_q   <= '0;
         nofs_q  <= '0;
         cur_q   <= BASE_P;
         prv_q   <= '0;
         nnext_q <= '0;
         tail_q  <= '0;
         found_q <= 1'b0;
         err_q   <= ERR_NONE;
         cap_q   <= '0;
         prev_q  <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (op_valid) begin
                  app_q   <= op_append;
                  first_q <= op_append && (op_ofs == BASE_P);
                  tgt_q   <= op_id;
                  ver_q   <= op_ver;
                  nofs_q  <= op_ofs;
                  cur_q   <= BASE_P;
                  prv_q   <= '0;
                  nnext_q <= '0;
                  found_q <= 1'b0;
                  err_q   <= ERR_NONE;
                  cap_q   <= '0;
                  prev_q  <= '0;
                  if (op_append && new_bad_range) begin
                     err_q <= ERR_RANGE;
                     st    <= S_FIN;
                  end else if (op_append && new_bad_align) begin
                     err_q <= ERR_ALIGN;
                     st    <= S_FIN;
                  end else begin
                     st <= S_READ;
                  end
               end
            end
            S_READ: st <= S_EVAL;
            S_EVAL: begin
               if (first_q) begin
                  nnext_q <= rd_next;
                  cap_q   <= nofs_q;
                  st      <= S_WR_NEW;
               end else if ((cur_q == BASE_P) && (mem_rdata == '0)) begin
                  if (app_q) err_q <= ERR_EMPTY;
                  st <= S_FIN;
               end else if (!app_q && (tgt_q != '0) && (rd_id == tgt_q)) begin
                  found_q <= 1'b1;
                  cap_q   <= cur_q;
                  prev_q  <= prv_q;
                  st      <= S_FIN;
               end else if (rd_next == '0) begin
                  prev_q <= cur_q;
                  if (app_q) begin
                     tail_q  <= mem_rdata;
                     cap_q   <= nofs_q;
                     nnext_q <= '0;
                     st      <= S_WR_TAIL;
                  end else begin
                     st <= S_FIN;
                  end
               end else if (nxt_bad_range) begin
                  err_q  <= ERR_RANGE;
                  prev_q <= cur_q;
                  st     <= S_FIN;
               end else if (nxt_bad_align) begin
                  err_q  <= ERR_ALIGN;
                  prev_q <= cur_q;
                  st     <= S_FIN;
               end else if (at_limit) begin
                  err_q  <= ERR_LOOP;
                  prev_q <= cur_q;
                  st     <= S_FIN;
               end else begin
                  prv_q <= cur_q;
                  cur_q <= rd_next;
                  st    <= S_READ;
               end
            end
            S_WR_TAIL: st <= S_WR_NEW;
            S_WR_NEW:  st <= S_FIN;
            S_FIN:     st <= S_IDLE;
            default:   st <= S_IDLE;
         endcase
      end
   end

   logic unused_lsb;
   assign unused_lsb = ^{cur_q[AL_B-1:0], nofs_q[AL_B-1:0]};

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q[OFS_W-1:AL_B];
      mem_wdata = '0;
      case (st)
         S_READ: begin
            mem_req = 1'b1;
         end
         S_WR_TAIL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = patched_hdr;
         end
         S_WR_NEW: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = nofs_q[OFS_W-1:AL_B];
            mem_wdata = new_hdr;
         end
         default: ;
      endcase
   end

   assign busy     = (st != S_IDLE);
   assign done     = (st == S_FIN);
   assign found    = found_q;
   assign err_code = err_q;
   assign cap_ofs  = cap_q;
   assign prev_ofs = prev_q;

endmodule

// File: rtl/ecw_checker.sv
module ecw_checker #(
   parameter int OFS_W       = 12,
   parameter int BASE_OFS    = 256,
   parameter int SPACE_BYTES = 4096,
   parameter int ALIGN_BYTES = 4
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 op_valid,
   input logic                                 busy,
   input logic                                 done,
   input logic                                 found,
   input logic [2:0]                           err_code,
   input logic [OFS_W-1:0]                     cap_ofs,
   input logic                                 mem_req,
   input logic                                 mem_we,
   input logic [OFS_W-$clog2(ALIGN_BYTES)-1:0] mem_addr
);
   localparam int MA_W = OFS_W - $clog2(ALIGN_BYTES);
   localparam logic [MA_W-1:0] LO_W = MA_W'(BASE_OFS / ALIGN_BYTES);
   localparam logic [MA_W-1:0] HI_W = MA_W'((SPACE_BYTES - 8) / ALIGN_BYTES);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy) |=> busy);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R1
   write_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   // R5
   addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr >= LO_W) && (mem_addr <= HI_W)));

   // R2
   found_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> ((err_code == 3'd0) && (cap_ofs[1:0] == 2'b00)));

endmodule

bind ecap_chain_walker ecw_checker #(
   .OFS_W(OFS_W), .BASE_OFS(BASE_OFS),
   .SPACE_BYTES(SPACE_BYTES), .ALIGN_BYTES(ALIGN_BYTES)
) u_ecw_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .busy(busy), .done(done),
   .found(found), .err_code(err_code), .cap_ofs(cap_ofs),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_ecap_chain_walker.sv
`timescale 1ns/1ps
module tb_ecap_chain_walker;
   localparam int LIM = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_append = 1'b0;
   logic [15:0] op_id = '0;
   logic [3:0]  op_ver = '0;
   logic [11:0] op_ofs = '0;
   logic        busy, done, found;
   logic [2:0]  err_code;
   logic [11:0] cap_ofs, prev_ofs;
   logic        mem_req, mem_we;
   logic [9:0]  mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [0:1023];
   int acc_cnt = 0, wr_cnt = 0, n_chk = 0, n_err = 0;
   logic        r_found;
   logic [2:0]  r_err;
   logic [11:0] r_cap, r_prev;

   always #4 clk = ~clk;

   ecap_chain_walker #(.STEP_LIMIT(LIM)) dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_append(op_append),
      .op_id(op_id), .op_ver(op_ver), .op_ofs(op_ofs), .busy(busy),
      .done(done), .found(found), .err_code(err_code), .cap_ofs(cap_ofs),
      .prev_ofs(prev_ofs), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         acc_cnt = acc_cnt + 1;
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt = wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] eofs(input int k, input int stride);
      return 12'(256 + k * stride);
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
   endtask

   task automatic build(input int n, input int stride);
      for (int k = 0; k < n; k++) begin
         logic [11:0] nxt;
         nxt = (k == n - 1) ? 12'h000 : eofs(k + 1, stride);
         mem[eofs(k, stride) >> 2] = {nxt, 4'(k), 16'(k + 1)};
      end
   endtask

   task automatic run(input logic app, input logic [15:0] id,
                      input logic [3:0] ver, input logic [11:0] ofs);
      @(negedge clk);
      op_valid = 1'b1; op_append = app; op_id = id; op_ver = ver; op_ofs = ofs;
      acc_cnt = 0; wr_cnt = 0;
      @(negedge clk);
      op_valid = 1'b0;
      while (done !== 1'b1) @(negedge clk);
      r_found = found; r_err = err_code; r_cap = cap_ofs; r_prev = prev_ofs;
      @(negedge clk);
      chk("R11 done pulse", 32'(done), 32'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      chk("R11 reset busy", 32'(busy), 32'd0);
      chk("R11 reset done", 32'(done), 32'd0);
      chk("R11 reset mem_req", 32'(mem_req), 32'd0);
      chk("R11 reset err", 32'(err_code), 32'd0);
      rst_n = 1'b1;

      // R2 / R4 / R7 sweeps over list length and spacing
      for (int s = 0; s < 2; s++) begin
         int stride;
         stride = (s == 0) ? 'h40 : 'h10C;
         for (int n = 1; n <= LIM; n++) begin
            clear_mem(); build(n, stride);
            for (int k = 0; k < n; k++) begin
               run(1'b0, 16'(k + 1), 4'h0, 12'h0);
               chk("R2 found", 32'(r_found), 32'd1);
               chk("R2 cap", 32'(r_cap), 32'(eofs(k, stride)));
               chk("R2 prev", 32'(r_prev), (k == 0) ? 32'd0 : 32'(eofs(k - 1, stride)));
            end
            run(1'b0, 16'h7777, 4'h0, 12'h0);
            chk("R4 miss found", 32'(r_found), 32'd0);
            chk("R4 miss prev", 32'(r_prev), 32'(eofs(n - 1, stride)));
            chk("R7 no error within limit", 32'(r_err), 32'd0);
            run(1'b0, 16'h0000, 4'h0, 12'h0);
            chk("R4 id0 found", 32'(r_found), 32'd0);
            chk("R4 id0 prev", 32'(r_prev), 32'(eofs(n - 1, stride)));
         end
      end

      // R7 loop guard
      clear_mem(); build(LIM + 1, 'h40);
      run(1'b0, 16'h0000, 4'h0, 12'h0);
      chk("R7 too long", 32'(r_err), 32'd3);
      clear_mem(); mem[10'h040] = {12'h100, 4'h0, 16'h0001};
      run(1'b0, 16'h0002, 4'h0, 12'h0);
      chk("R7 self loop", 32'(r_err), 32'd3);

      // R5 / R6 bad links
      clear_mem(); build(3, 'h40);
      mem[10'h060] = {12'h0FC, 4'd2, 16'd3};
      run(1'b0, 16'h0009, 4'h0, 12'h0);
      chk("R5 below window", 32'(r_err), 32'd1);
      chk("R5 below window found", 32'(r_found), 32'd0);
      mem[10'h060] = {12'hFFC, 4'd2, 16'd3};
      run(1'b0, 16'h0009, 4'h0, 12'h0);
      chk("R5 above window", 32'(r_err), 32'd1);
      mem[10'h060] = {12'hFF9, 4'd2, 16'd3};
      run(1'b0, 16'h0009, 4'h0, 12'h0);
      chk("R5 range over align", 32'(r_err), 32'd1);
      mem[10'h060] = {12'h0FD, 4'd2, 16'd3};
      run(1'b0, 16'h0009, 4'h0, 12'h0);
      chk("R5 low misaligned", 32'(r_err), 32'd1);
      mem[10'h060] = {12'h202, 4'd2, 16'd3};
      run(1'b0, 16'h0009, 4'h0, 12'h0);
      chk("R6 misaligned", 32'(r_err), 32'd2);
      mem[10'h060] = {12'hFF5, 4'd2, 16'd3};
      run(1'b0, 16'h0009, 4'h0, 12'h0);
      chk("R6 misaligned high", 32'(r_err), 32'd2);
      mem[10'h060] = {12'hFF8, 4'd2, 16'd3};
      mem[10'h3FE] = {12'h000, 4'd7, 16'h00EE};
      run(1'b0, 16'h00EE, 4'h0, 12'h0);
      chk("R5 top edge found", 32'(r_found), 32'd1);
      chk("R5 top edge cap", 32'(r_cap), 32'hFF8);
      chk("R5 top edge prev", 32'(r_prev), 32'h180);

      // R3 empty list
      clear_mem();
      run(1'b0, 16'h0005, 4'h0, 12'h0);
      chk("R3 empty found", 32'(r_found), 32'd0);
      chk("R3 empty err", 32'(r_err), 32'd0);
      chk("R3 empty prev", 32'(r_prev), 32'd0);
      run(1'b1, 16'h0005, 4'h1, 12'h200);
      chk("R3 empty append err", 32'(r_err), 32'd4);
      chk("R3 empty append writes", 32'(wr_cnt), 32'd0);

      // R8 append at the first slot
      clear_mem();
      run(1'b1, 16'h0011, 4'h1, 12'h100);
      chk("R8 empty first slot", mem[10'h040], {12'h000, 4'h1, 16'h0011});
      clear_mem(); build(3, 'h40);
      run(1'b1, 16'hABCD, 4'h5, 12'h100);
      chk("R8 keep link", mem[10'h040], {12'h140, 4'h5, 16'hABCD});
      chk("R8 one write", 32'(wr_cnt), 32'd1);
      chk("R8 err", 32'(r_err), 32'd0);

      // R9 append at the tail, several list lengths
      for (int n = 1; n <= 4; n++) begin
         clear_mem(); build(n, 'h40);
         run(1'b1, 16'hBEE0 + 16'(n), 4'h3, 12'h800);
         chk("R9 tail patched", mem[eofs(n - 1, 'h40) >> 2], {12'h800, 4'(n - 1), 16'(n)});
         chk("R9 new header", mem[10'h200], {12'h000, 4'h3, 16'hBEE0 + 16'(n)});
         chk("R9 two writes", 32'(wr_cnt), 32'd2);
         chk("R9 prev is tail", 32'(r_prev), 32'(eofs(n - 1, 'h40)));
         chk("R9 cap is new", 32'(r_cap), 32'h800);
         run(1'b0, 16'hBEE0 + 16'(n), 4'h0, 12'h0);
         chk("R9 search new", 32'(r_cap), 32'h800);
         chk("R9 search new prev", 32'(r_prev), 32'(eofs(n - 1, 'h40)));
      end

      // R10 bad append offsets
      clear_mem(); build(2, 'h40);
      run(1'b1, 16'h0033, 4'h2, 12'h0FC);
      chk("R10 low offset", 32'(r_err), 32'd1);
      chk("R10 low no access", 32'(acc_cnt), 32'd0);
      run(1'b1, 16'h0033, 4'h2, 12'hFFC);
      chk("R10 high offset", 32'(r_err), 32'd1);
      run(1'b1, 16'h0033, 4'h2, 12'h802);
      chk("R10 misaligned", 32'(r_err), 32'd2);
      chk("R10 misaligned no access", 32'(acc_cnt), 32'd0);

      // R11 requests while busy are ignored, results hold
      clear_mem(); build(4, 'h40);
      @(negedge clk);
      op_valid = 1'b1; op_append = 1'b0; op_id = 16'd2;
      @(negedge clk);
      op_id = 16'd3;
      repeat (3) @(negedge clk);
      op_valid = 1'b0;
      while (done !== 1'b1) @(negedge clk);
      chk("R11 busy ignore cap", 32'(cap_ofs), 32'(eofs(1, 'h40)));
      repeat (5) @(negedge clk);
      chk("R11 result holds", 32'(cap_ofs), 32'(eofs(1, 'h40)));
      chk("R11 idle after op", 32'(busy), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule